// File: doc/BRIEF.md
# Split-Issue Fused Multiply-Add Reservation Station

This block is a small reservation station for a floating-point cluster. It runs each three-operand fused multiply-add as two separate issues. The first issue is a multiply of the two product operands, A and B. The second is an add of that product to the addend, C. Each entry holds three source operands, each with a tag, a ready bit and a data word. A result-broadcast port wakes up operands that are still waiting.

The multiply may issue as soon as A and B are present, even if C is still missing. When the multiply issues, the entry is marked as having its intermediate product ready, before the product has actually returned. The external multiplier hands the product back exactly two cycles after the multiply issue, and the product is stored in the A slot.

If C is already ready, the entry is selected one cycle after the multiply issue and the add issues the cycle after that. The add then takes the product straight from the return port. If C arrives later, the add reads the product back from the entry's storage. The entry stays occupied until its add issue is accepted. A flush clears every entry whatever its state.

Top module: `rs_fma_split`

## Requirements
- R1: `alloc_ready` is high exactly when at least one entry is free, and an allocation takes the lowest-numbered free entry. Within `alloc_tags`, `alloc_rdy` and `alloc_data`, field 0 (the lowest bits) is operand A, field 1 is B and field 2 is the addend C.
- R2: `mul_issue_valid` is raised for an entry whose A and B are ready, whatever the state of C. It presents that entry's A and B on `mul_op_a`/`mul_op_b` and its index on `mul_issue_idx`.
- R3: When several entries request the same issue port, the entry allocated earliest wins, regardless of its index.
- R4: A broadcast on `wb_valid`/`wb_tag` marks every waiting operand with a matching tag ready and stores `wb_data` in it. This includes an operand being allocated in that same cycle.
- R5: An accepted multiply issue does not free its entry, so a full station stays full.
- R6: An add issue needs both the intermediate-ready mark and a ready C. With C ready, `add_issue_valid` rises two cycles after the multiply issue is accepted, and never before C is ready.
- R7: When the multiply result for the entry being add-issued is on the return port in that cycle, `add_op_x` equals `mul_res_data` and `add_bypass` is 1.
- R8: When C arrives after the multiply, the add reads the stored product: `add_op_x` is the product, `add_op_c` is C, and `add_bypass` is 0.
- R9: While `add_issue_ready` is low, the add issue holds the same index and operands.
- R10: An accepted add issue frees the entry, and `alloc_ready` rises in the next cycle.
- R11: `flush` invalidates every entry and the pending add. Afterwards no issue comes from the old entries, even after their operands are woken, and a late product for a flushed entry does not disturb a new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | A free entry exists |
| alloc_tags | input | 3*TAG_W | Source tags, field 0 = A, 1 = B, 2 = C |
| alloc_rdy | input | 3 | Source already-available bits |
| alloc_data | input | 3*DATA_W | Source data for available operands |
| wb_valid | input | 1 | Result broadcast valid |
| wb_tag | input | TAG_W | Broadcast tag |
| wb_data | input | DATA_W | Broadcast data |
| mul_issue_valid | output | 1 | Multiply issue request |
| mul_issue_ready | input | 1 | Multiplier accepts |
| mul_issue_idx | output | IDX_W | Entry issuing the multiply |
| mul_op_a | output | DATA_W | Product operand A |
| mul_op_b | output | DATA_W | Product operand B |
| mul_res_valid | input | 1 | Product return valid |
| mul_res_idx | input | IDX_W | Entry the product belongs to |
| mul_res_data | input | DATA_W | Product value |
| add_issue_valid | output | 1 | Add issue request |
| add_issue_ready | input | 1 | Adder accepts |
| add_issue_idx | output | IDX_W | Entry issuing the add |
| add_op_x | output | DATA_W | Product operand of the add |
| add_op_c | output | DATA_W | Addend operand |
| add_bypass | output | 1 | Product taken from the return port |

## Verification
The case that matters most is when a product comes back on the return port in the same cycle that its own entry is add-issued. The bench sets this up by allocating an entry whose addend is already present and letting its multiply issue at once. It then requires the add to appear exactly two cycles later, carrying the product the bench computes itself and with the bypass flag set. Rows whose addend is woken a few cycles later must instead show the stored product with the flag clear. A further case issues a multiply, flushes, and re-allocates so that a stale product lands in the allocation cycle; the new entry's operand must survive.

// File: rtl/rs_fma_pkg.sv
package rs_fma_pkg;
  // operand slots of an entry; slot A later holds the intermediate product
  localparam int NSRC   = 3;
  localparam int SLOT_A = 0;
  localparam int SLOT_B = 1;
  localparam int SLOT_C = 2;
  // issue ports served by the age selector
  localparam int PORT_MUL = 0;
  localparam int PORT_ADD = 1;
  localparam int NPORTS   = 2;
endpackage

// File: rtl/rs_fma_age_sel.sv
module rs_fma_age_sel #(
  parameter int N      = 4,
  parameter int PORTS  = 2,
  parameter int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_fire,
  input  logic [IDX_W-1:0]   alloc_idx,
  input  logic [PORTS*N-1:0] req,
  output logic [PORTS*N-1:0] gnt
);
  // elder_q[i][j] : entry i was allocated before entry j
  logic [N-1:0] elder_q   [N];
  logic [N-1:0] beaten_by [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) elder_q[i] <= '0;
    end else if (alloc_fire) begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (IDX_W'(i) == alloc_idx)      elder_q[i][j] <= 1'b0;
          else if (IDX_W'(j) == alloc_idx) elder_q[i][j] <= 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_col
    for (genvar j = 0; j < N; j++) begin : g_bit
      assign beaten_by[i][j] = elder_q[j][i];
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    for (genvar i = 0; i < N; i++) begin : g_ent
      assign gnt[p*N+i] = req[p*N+i] & ~|(req[p*N +: N] & beaten_by[i]);
    end
  end
endmodule

// File: rtl/rs_fma_slot.sv
module rs_fma_slot
  import rs_fma_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   alloc_en,
  input  logic [NSRC*TAG_W-1:0]  alloc_tags,
  input  logic [NSRC-1:0]        alloc_rdy,
  input  logic [NSRC*DATA_W-1:0] alloc_data,
  input  logic                   wb_valid,
  input  logic [TAG_W-1:0]       wb_tag,
  input  logic [DATA_W-1:0]      wb_data,
  input  logic                   mul_fire,
  input  logic                   res_en,
  input  logic [DATA_W-1:0]      res_data,
  input  logic                   add_sel,
  input  logic                   add_fire,
  output logic                   valid_o,
  output logic                   mid_o,
  output logic                   c_rdy_o,
  output logic                   mul_req_o,
  output logic                   add_req_o,
  output logic [DATA_W-1:0]      op_a_o,
  output logic [DATA_W-1:0]      op_b_o,
  output logic [DATA_W-1:0]      op_c_o
);
  logic                valid_q;
  logic                mid_q;     // multiply issued: product counted as ready
  logic                in_add_q;  // held in the add staging register
  logic [NSRC-1:0]     rdy_q;
  logic [TAG_W-1:0]    tag_q  [NSRC];
  logic [DATA_W-1:0]   data_q [NSRC];

  function automatic logic tag_hit(input logic v, input logic [TAG_W-1:0] bus_tag,
                                   input logic [TAG_W-1:0] own_tag);
    return v && (bus_tag == own_tag);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      mid_q    <= 1'b0;
      in_add_q <= 1'b0;
      rdy_q    <= '0;
      for (int s = 0; s < NSRC; s++) begin
        tag_q[s]  <= '0;
        data_q[s] <= '0;
      end
    end else if (flush) begin
      valid_q  <= 1'b0;
      mid_q    <= 1'b0;
      in_add_q <= 1'b0;
    end else if (alloc_en) begin
      valid_q  <= 1'b1;
      mid_q    <= 1'b0;
      in_add_q <= 1'b0;
      for (int s = 0; s < NSRC; s++) begin
        tag_q[s] <= alloc_tags[s*TAG_W +: TAG_W];
        if (alloc_rdy[s]) begin
          rdy_q[s]  <= 1'b1;
          data_q[s] <= alloc_data[s*DATA_W +: DATA_W];
        end else if (tag_hit(wb_valid, wb_tag, alloc_tags[s*TAG_W +: TAG_W])) begin
          rdy_q[s]  <= 1'b1;
          data_q[s] <= wb_data;
        end else begin
          rdy_q[s]  <= 1'b0;
        end
      end
    end else if (valid_q) begin
      for (int s = 0; s < NSRC; s++) begin
        if (!rdy_q[s] && tag_hit(wb_valid, wb_tag, tag_q[s])) begin
          rdy_q[s]  <= 1'b1;
          data_q[s] <= wb_data;
        end
      end
      if (mul_fire) mid_q <= 1'b1;
      if (res_en && mid_q) data_q[SLOT_A] <= res_data;
      if (add_sel) in_add_q <= 1'b1;
      if (add_fire) begin
        valid_q  <= 1'b0;
        mid_q    <= 1'b0;
        in_add_q <= 1'b0;
      end
    end
  end

  assign valid_o   = valid_q;
  assign mid_o     = mid_q;
  assign c_rdy_o   = rdy_q[SLOT_C];
  assign mul_req_o = valid_q && rdy_q[SLOT_A] && rdy_q[SLOT_B] && !mid_q;
  assign add_req_o = valid_q && mid_q && rdy_q[SLOT_C] && !in_add_q;
  assign op_a_o    = data_q[SLOT_A];
  assign op_b_o    = data_q[SLOT_B];
  assign op_c_o    = data_q[SLOT_C];
endmodule

// File: rtl/rs_fma_split.sv
module rs_fma_split
  import rs_fma_pkg::*;
#(
  parameter int N      = 4,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 5,
  parameter int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   alloc_valid,
  output logic                   alloc_ready,
  input  logic [3*TAG_W-1:0]     alloc_tags,
  input  logic [2:0]             alloc_rdy,
  input  logic [3*DATA_W-1:0]    alloc_data,
  input  logic                   wb_valid,
  input  logic [TAG_W-1:0]       wb_tag,
  input  logic [DATA_W-1:0]      wb_data,
  output logic                   mul_issue_valid,
  input  logic                   mul_issue_ready,
  output logic [IDX_W-1:0]       mul_issue_idx,
  output logic [DATA_W-1:0]      mul_op_a,
  output logic [DATA_W-1:0]      mul_op_b,
  input  logic                   mul_res_valid,
  input  logic [IDX_W-1:0]       mul_res_idx,
  input  logic [DATA_W-1:0]      mul_res_data,
  output logic                   add_issue_valid,
  input  logic                   add_issue_ready,
  output logic [IDX_W-1:0]       add_issue_idx,
  output logic [DATA_W-1:0]      add_op_x,
  output logic [DATA_W-1:0]      add_op_c,
  output logic                   add_bypass
);
  // named internal events, also observed by the checker
  logic [N-1:0]        valid_vec, mid_vec, crdy_vec;
  logic [N-1:0]        mul_req_vec, add_req_vec;
  logic [N-1:0]        mul_gnt, add_gnt;
  logic [N-1:0]        alloc_onehot, add_sel_vec;
  logic [IDX_W-1:0]    alloc_idx, add_pick_idx;
  logic                alloc_fire, mul_fire, add_fire, add_take, res_hit;
  logic                stage_v_q;
  logic [IDX_W-1:0]    stage_idx_q;
  logic [DATA_W-1:0]   slot_a [N];
  logic [DATA_W-1:0]   slot_b [N];
  logic [DATA_W-1:0]   slot_c [N];

  function automatic logic [IDX_W-1:0] lowest_set(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] onehot_idx(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) if (v[i]) r = r | IDX_W'(i);
    return r;
  endfunction

  // allocation: lowest free index
  assign alloc_ready = ~&valid_vec;
  assign alloc_idx   = lowest_set(~valid_vec);
  assign alloc_fire  = alloc_valid && alloc_ready && !flush;

  for (genvar i = 0; i < N; i++) begin : g_oh
    assign alloc_onehot[i] = alloc_fire && (alloc_idx == IDX_W'(i));
  end

  // oldest-first selection for both issue ports
  rs_fma_age_sel #(.N(N), .PORTS(NPORTS), .IDX_W(IDX_W)) u_age (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_fire (alloc_fire),
    .alloc_idx  (alloc_idx),
    .req        ({add_req_vec, mul_req_vec}),
    .gnt        ({add_gnt, mul_gnt})
  );

  // multiply issue straight from the entries
  assign mul_issue_valid = (|mul_req_vec) && !flush;
  assign mul_issue_idx   = onehot_idx(mul_gnt);
  assign mul_op_a        = slot_a[mul_issue_idx];
  assign mul_op_b        = slot_b[mul_issue_idx];
  assign mul_fire        = mul_issue_valid && mul_issue_ready;

  // add staging register: select one cycle, issue the next
  assign add_issue_valid = stage_v_q && !flush;
  assign add_issue_idx   = stage_idx_q;
  assign add_fire        = add_issue_valid && add_issue_ready;
  assign add_take        = (!stage_v_q || add_fire) && (|add_req_vec) && !flush;
  assign add_pick_idx    = onehot_idx(add_gnt);
  assign add_sel_vec     = add_take ? add_gnt : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      stage_v_q   <= 1'b0;
      stage_idx_q <= '0;
    end else if (add_take) begin
      stage_v_q   <= 1'b1;
      stage_idx_q <= add_pick_idx;
    end else if (add_fire) begin
      stage_v_q   <= 1'b0;
    end
  end

  // product operand: catch it on the return port, else read storage
  assign res_hit    = mul_res_valid && (mul_res_idx == stage_idx_q);
  assign add_op_x   = res_hit ? mul_res_data : slot_a[stage_idx_q];
  assign add_op_c   = slot_c[stage_idx_q];
  assign add_bypass = add_issue_valid && res_hit;

  for (genvar i = 0; i < N; i++) begin : g_ent
    rs_fma_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .alloc_en   (alloc_onehot[i]),
      .alloc_tags (alloc_tags),
      .alloc_rdy  (alloc_rdy),
      .alloc_data (alloc_data),
      .wb_valid   (wb_valid),
      .wb_tag     (wb_tag),
      .wb_data    (wb_data),
      .mul_fire   (mul_fire && mul_gnt[i]),
      .res_en     (mul_res_valid && (mul_res_idx == IDX_W'(i))),
      .res_data   (mul_res_data),
      .add_sel    (add_sel_vec[i]),
      .add_fire   (add_fire && (stage_idx_q == IDX_W'(i))),
      .valid_o    (valid_vec[i]),
      .mid_o      (mid_vec[i]),
      .c_rdy_o    (crdy_vec[i]),
      .mul_req_o  (mul_req_vec[i]),
      .add_req_o  (add_req_vec[i]),
      .op_a_o     (slot_a[i]),
      .op_b_o     (slot_b[i]),
      .op_c_o     (slot_c[i])
    );
  end
endmodule

// File: rtl/rs_fma_split_chk.sv
module rs_fma_split_chk #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             mul_fire,
  input logic             add_fire,
  input logic [IDX_W-1:0] mul_issue_idx,
  input logic [IDX_W-1:0] add_issue_idx,
  input logic             add_issue_valid,
  input logic             add_bypass,
  input logic [N-1:0]     valid_vec,
  input logic [N-1:0]     mid_vec,
  input logic [N-1:0]     crdy_vec,
  input logic [N-1:0]     mul_gnt
);
  // R3
  mul_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mul_gnt));

  // R5
  mul_keeps_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mul_fire |=> valid_vec[$past(mul_issue_idx)]);

  // R6
  add_needs_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_issue_valid |-> (mid_vec[add_issue_idx] && crdy_vec[add_issue_idx]));

  // R7
  bypass_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_bypass |-> ($past(mul_fire, 2) && ($past(mul_issue_idx, 2) == add_issue_idx)));

  // R10
  add_frees_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_fire |=> !valid_vec[$past(add_issue_idx)]);

  // R11
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0) && !add_issue_valid);
endmodule

bind rs_fma_split rs_fma_split_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .flush           (flush),
  .mul_fire        (mul_fire),
  .add_fire        (add_fire),
  .mul_issue_idx   (mul_issue_idx),
  .add_issue_idx   (add_issue_idx),
  .add_issue_valid (add_issue_valid),
  .add_bypass      (add_bypass),
  .valid_vec       (valid_vec),
  .mid_vec         (mid_vec),
  .crdy_vec        (crdy_vec),
  .mul_gnt         (mul_gnt)
);

// File: tb/tb_rs_fma_split.sv
module tb_rs_fma_split;
  localparam int N = 4, DW = 16, TW = 5, IW = 2;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic alloc_valid = 1'b0, alloc_ready;
  logic [3*TW-1:0] alloc_tags = '0;
  logic [2:0]      alloc_rdy = '0;
  logic [3*DW-1:0] alloc_data = '0;
  logic wb_valid = 1'b0;
  logic [TW-1:0] wb_tag = '0;
  logic [DW-1:0] wb_data = '0;
  logic mul_issue_valid, mul_issue_ready = 1'b1;
  logic [IW-1:0] mul_issue_idx;
  logic [DW-1:0] mul_op_a, mul_op_b;
  logic mul_res_valid;
  logic [IW-1:0] mul_res_idx;
  logic [DW-1:0] mul_res_data;
  logic add_issue_valid, add_issue_ready = 1'b1;
  logic [IW-1:0] add_issue_idx;
  logic [DW-1:0] add_op_x, add_op_c;
  logic add_bypass;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  rs_fma_split #(.N(N), .DATA_W(DW), .TAG_W(TW)) dut (.*);

  // multiplier model: fixed two-cycle latency
  function automatic logic [DW-1:0] prod(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [2*DW-1:0] full;
    full = a * b;
    return full[DW-1:0];
  endfunction

  logic p1_v, p2_v;
  logic [IW-1:0] p1_i, p2_i;
  logic [DW-1:0] p1_d, p2_d;
  always @(posedge clk) begin
    if (!rst_n) begin
      p1_v <= 1'b0; p2_v <= 1'b0;
    end else begin
      p1_v <= mul_issue_valid && mul_issue_ready;
      p1_i <= mul_issue_idx;
      p1_d <= prod(mul_op_a, mul_op_b);
      p2_v <= p1_v; p2_i <= p1_i; p2_d <= p1_d;
    end
  end
  assign mul_res_valid = p2_v;
  assign mul_res_idx   = p2_i;
  assign mul_res_data  = p2_d;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_alloc(input logic [TW-1:0] ta, input logic [TW-1:0] tb_, input logic [TW-1:0] tc,
                          input logic [2:0] r, input logic [DW-1:0] da, input logic [DW-1:0] db,
                          input logic [DW-1:0] dc);
    alloc_valid = 1'b1;
    alloc_tags  = {tc, tb_, ta};
    alloc_rdy   = r;
    alloc_data  = {dc, db, da};
    tick();
    alloc_valid = 1'b0;
  endtask

  task automatic wait_add();
    for (int n = 0; n < 16 && !add_issue_valid; n++) tick();
  endtask

  // stimulus rows: {A, B, C, cycles before C is woken (0 = ready at allocation)}
  localparam logic [63:0] ROWS [4] = '{
    {16'h0003, 16'h0005, 16'h0007, 16'd0},
    {16'h0101, 16'h00ff, 16'h1234, 16'd1},
    {16'hffff, 16'h0002, 16'h0009, 16'd0},
    {16'h0040, 16'h0400, 16'hbeef, 16'd3}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // reset state (R1)
    chk("R1 reset alloc_ready", 32'(alloc_ready), 32'd1);
    chk("R2 reset mul_issue_valid", 32'(mul_issue_valid), 32'd0);
    chk("R6 reset add_issue_valid", 32'(add_issue_valid), 32'd0);

    // table walk: bypass versus stored product (R7, R8)
    for (int r = 0; r < 4; r++) begin
      logic [DW-1:0] a, b, c;
      int dly;
      a = ROWS[r][63:48]; b = ROWS[r][47:32]; c = ROWS[r][31:16]; dly = int'(ROWS[r][15:0]);
      do_alloc(5'd1, 5'd2, 5'd5, {(dly == 0), 2'b11}, a, b, (dly == 0) ? c : '0);
      if (dly > 0) begin
        repeat (dly) tick();
        wb_valid = 1'b1; wb_tag = 5'd5; wb_data = c;
        tick();
        wb_valid = 1'b0;
      end
      wait_add();
      chk((dly == 0) ? "R7 add_op_x" : "R8 add_op_x", 32'(add_op_x), 32'(prod(a, b)));
      chk("R8 add_op_c", 32'(add_op_c), 32'(c));
      chk("R7 add_bypass", 32'(add_bypass), 32'(dly == 0));
      tick(); tick();
    end

    // oldest-first with a younger entry in a lower index (R3, R1, R4)
    do_alloc(5'd1, 5'd2, 5'd3, 3'b111, 16'd2, 16'd3, 16'd4);   // idx0, completes
    do_alloc(5'd9, 5'd9, 5'd14, 3'b000, '0, '0, '0);           // idx1, older waiter
    repeat (6) tick();
    do_alloc(5'd9, 5'd9, 5'd3, 3'b100, '0, '0, 16'd6);         // idx0, younger
    wb_valid = 1'b1; wb_tag = 5'd9; wb_data = 16'h0021;
    tick();
    wb_valid = 1'b0;
    chk("R3 older entry first", 32'(mul_issue_idx), 32'd1);
    chk("R4 woken operand data", 32'(mul_op_a), 32'h21);
    tick();
    chk("R1 lowest free index", 32'(mul_issue_idx), 32'd0);
    wait_add();
    chk("R6 add idx", 32'(add_issue_idx), 32'd0);
    chk("R7 bypass product", 32'(add_op_x), 32'h0441);
    repeat (3) tick();

    // wakeup in the allocation cycle (R4)
    wb_valid = 1'b1; wb_tag = 5'd20; wb_data = 16'h0aaa;
    do_alloc(5'd20, 5'd21, 5'd22, 3'b000, '0, '0, '0);
    wb_tag = 5'd21; wb_data = 16'h0bbb;
    tick();
    wb_valid = 1'b0;
    chk("R4 alloc-cycle wakeup valid", 32'(mul_issue_valid), 32'd1);
    chk("R4 alloc-cycle wakeup A", 32'(mul_op_a), 32'h0aaa);
    chk("R4 later wakeup B", 32'(mul_op_b), 32'h0bbb);

    // flush (R11)
    flush = 1'b1;
    tick();
    flush = 1'b0;
    chk("R11 alloc_ready after flush", 32'(alloc_ready), 32'd1);
    chk("R11 mul idle after flush", 32'(mul_issue_valid), 32'd0);
    wb_valid = 1'b1; wb_tag = 5'd14; wb_data = 16'h0005;
    tick();
    wb_valid = 1'b0;
    begin
      logic seen;
      seen = 1'b0;
      for (int n = 0; n < 5; n++) begin
        seen = seen | add_issue_valid | mul_issue_valid;
        tick();
      end
      chk("R11 no issue from flushed entries", 32'(seen), 32'd0);
    end

    // full station, late C, add stall, free on add (R5, R6, R8, R9, R10)
    for (int i = 0; i < 4; i++)
      do_alloc(5'd1, 5'd2, 5'd15, 3'b011, DW'(i + 2), DW'(i + 3), '0);
    chk("R1 full alloc_ready", 32'(alloc_ready), 32'd0);
    repeat (6) tick();
    chk("R5 still full after multiplies", 32'(alloc_ready), 32'd0);
    chk("R6 no add without C", 32'(add_issue_valid), 32'd0);
    add_issue_ready = 1'b0;
    wb_valid = 1'b1; wb_tag = 5'd15; wb_data = 16'h0077;
    tick();
    wb_valid = 1'b0;
    wait_add();
    chk("R8 stored product", 32'(add_op_x), 32'd6);
    chk("R8 addend", 32'(add_op_c), 32'h77);
    chk("R8 no bypass", 32'(add_bypass), 32'd0);
    chk("R3 add oldest first", 32'(add_issue_idx), 32'd0);
    tick();
    chk("R9 stall holds valid", 32'(add_issue_valid), 32'd1);
    chk("R9 stall holds idx", 32'(add_issue_idx), 32'd0);
    chk("R9 stall holds operand", 32'(add_op_x), 32'd6);
    add_issue_ready = 1'b1;
    tick();
    chk("R10 entry freed", 32'(alloc_ready), 32'd1);
    chk("R10 next add idx", 32'(add_issue_idx), 32'd1);
    chk("R10 next product", 32'(add_op_x), 32'd12);
    repeat (8) tick();

    // stale product after flush must not disturb a new entry (R11)
    do_alloc(5'd1, 5'd2, 5'd16, 3'b011, 16'd5, 16'd6, '0);
    tick();
    flush = 1'b1;
    tick();
    flush = 1'b0;
    do_alloc(5'd1, 5'd2, 5'd3, 3'b111, 16'h0321, 16'h0010, 16'h0001);
    chk("R11 new entry issues", 32'(mul_issue_valid), 32'd1);
    chk("R11 new entry operand kept", 32'(mul_op_a), 32'h0321);
    wait_add();
    chk("R11 new entry product", 32'(add_op_x), 32'h3210);
    chk("R7 new entry bypass", 32'(add_bypass), 32'd1);
    repeat (3) tick();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule